// File: doc/BRIEF.md
# Request/Grant Bus Handover Controller

This block sits beside a processor's bus unit and lets up to two other bus masters borrow the local bus. Each master shares one active-low wire with the processor. The master signals a request with a one-clock low pulse. The processor answers with its own one-clock low pulse, the grant, and then floats the bus. Later the master sends a second one-clock low pulse to return the bus. The block reads the bus unit's T-state and the flags that describe the current cycle. From these it decides the exact clock in which the grant may be issued. While the bus is lent out, it stalls the bus unit.

Both wires have a weak pull-up, so the testbench models each wire as the wired-AND of the master's drive and the block's open-drain pull. The wire reads low whenever either side drives it. Channel 0 always wins over channel 1. A request that cannot be served at once stays pending until the bus can be handed over. At least one idle clock separates any two exchanges.

The block also generates the lock output. It is low while a locked instruction runs, and it is also low across the two cycles of an interrupt-acknowledge pair.

Top module: `rqgt_handover`

## Requirements
- R1: After reset, `rq_pull` is 00, `bus_float` and `stall` are 0, and `lock_n` is 1.
- R2: A request is detected when a wire is high in one clock and low in the next, while the block is not pulling that wire. A wire held low for several clocks counts as one request. If the bus is idle (`tstate` = 0) and no lock is active, the grant pulse appears on that channel's `rq_pull` bit in the clock right after the request clock, for exactly one clock.
- R3: `bus_float` and `stall` go high in the clock after the grant pulse. They stay high through the clock in which the owner's release pulse is seen, and are low in the following clock.
- R4: A grant is only ever issued when `tstate` is 0 (idle) or 4 (T4). Other encodings are T1=1, T2=2, T3=3 and wait=5. At T4, a grant requires that the request was seen while `tstate` was 0, 1 or 2. A request first seen at T3 is served at the next cycle's T4.
- R5: At T4, `odd_low` = 1 or `first_ack` = 1 blocks the grant. The request stays pending.
- R6: While `locked` is 1 or the acknowledge lock is set, no grant is issued. The pending request is granted in the first clock in which the lock is clear and the bus is idle.
- R7: When both channels are pending at the grant point, channel 0 (`rq_pull` = 01) is granted first.
- R8: After the clock in which `bus_float` falls, one idle clock passes with no grant. A request from the other channel is then served. This holds even if that request arrived before or during the hold, including in the same clock as the owner's release pulse.
- R9: `lock_n` goes low in the clock after T2 of an acknowledge cycle (`inta_cyc` = 1) with `first_ack` = 1. It returns high in the clock after T2 of the next acknowledge cycle with `first_ack` = 0. It is also low whenever `locked` = 1, and it is forced high while `bus_float` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tstate | input | 3 | Bus unit state: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait |
| odd_low | input | 1 | Current cycle is the low byte of an odd-address word |
| first_ack | input | 1 | Current cycle is the first of an acknowledge pair |
| inta_cyc | input | 1 | Current cycle is an interrupt-acknowledge cycle |
| locked | input | 1 | A locked instruction is executing |
| rq_in | input | NCH | Sampled level of each request/grant wire |
| rq_pull | output | NCH | Open-drain pull-low drive, one bit per wire |
| bus_float | output | 1 | Bus and control lines released |
| stall | output | 1 | Bus unit must not start a cycle |
| lock_n | output | 1 | Lock output, active low |

## Verification
Two events are made to land in the same clock: the owner's release pulse on one wire and a new request pulse on the other wire. The bench checks that the release ends the hold, that the new request is kept rather than lost or mistaken for a release, and that the new request is granted only after the idle clock. A second collision happens when the timing window and a blocking flag meet at the same T4. A request pending since T1 is driven against `odd_low` or `first_ack` at T4, and the bench expects no grant until a later T4 where the flags are clear.

// File: rtl/rqgt_handover.sv
module rqgt_handover #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     tstate,
  input  logic           odd_low,
  input  logic           first_ack,
  input  logic           inta_cyc,
  input  logic           locked,
  input  logic [NCH-1:0] rq_in,
  output logic [NCH-1:0] rq_pull,
  output logic           bus_float,
  output logic           stall,
  output logic           lock_n
);
  localparam logic [2:0] TS_IDLE = 3'd0;
  localparam logic [2:0] TS_T2   = 3'd2;
  localparam logic [2:0] TS_T4   = 3'd4;

  typedef enum logic [1:0] {S_OWN, S_HOLD, S_GAP} st_t;

  st_t            st;
  logic [NCH-1:0] wire_q, pend, pend_nx, seen, pick, owner;
  logic           early, ack_lk, lock_any, win, go;

  assign seen     = wire_q & ~rq_in & ~rq_pull;
  assign lock_any = locked | ack_lk;
  assign win      = (tstate == TS_IDLE) ||
                    (tstate == TS_T4 && early && !odd_low && !first_ack);
  assign go       = (st == S_OWN) && (|pend) && win && !lock_any;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NCH; i++)
      if (pend[i] && pick == '0) pick[i] = 1'b1;
  end

  assign rq_pull   = go ? pick : '0;
  assign pend_nx   = (pend & ~rq_pull) | (seen & ~((st == S_HOLD) ? owner : '0));
  assign bus_float = (st == S_HOLD);
  assign stall     = (st == S_HOLD);
  assign lock_n    = (st == S_HOLD) || !lock_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wire_q <= '1;
      pend   <= '0;
      owner  <= '0;
      early  <= 1'b0;
      ack_lk <= 1'b0;
      st     <= S_OWN;
    end else begin
      wire_q <= rq_in;
      pend   <= pend_nx;
      early  <= (|pend_nx) && ((early && !go) || tstate <= TS_T2);
      if (tstate == TS_T2 && inta_cyc) ack_lk <= first_ack;
      case (st)
        S_OWN:   if (go) begin st <= S_HOLD; owner <= pick; end
        S_HOLD:  if (|(seen & owner)) st <= S_GAP;
        default: st <= S_OWN;
      endcase
    end
  end

  AST_PULL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rq_pull)); // R7
  AST_GRANT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|rq_pull) |-> (tstate == TS_IDLE || tstate == TS_T4)); // R4
  AST_FLOAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rq_pull) |=> (bus_float && stall)); // R3
  AST_T4_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rq_pull) && tstate == TS_T4) |-> (!odd_low && !first_ack)); // R5
  AST_LOCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|rq_pull) |-> !locked); // R6
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_float) |-> (rq_pull == '0)); // R8
  AST_LOCK_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_float |-> lock_n); // R9
endmodule

// File: tb/rqgt_handover_tb.sv
module rqgt_handover_tb;
  localparam logic [2:0] TI = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3, T4 = 3'd4;
  localparam logic [3:0] F_NONE = 4'b0000, F_LOCK = 4'b0001, F_INTA = 4'b0010,
                         F_FIRST = 4'b0100, F_ODD = 4'b1000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] tstate = TI;
  logic       odd_low = 1'b0, first_ack = 1'b0, inta_cyc = 1'b0, locked = 1'b0;
  logic [1:0] m_low = 2'b00;
  logic [1:0] rq_in, rq_pull;
  logic       bus_float, stall, lock_n;
  int         cyc = 0, total = 0, bad = 0;
  bit         done = 1'b0;

  typedef struct {
    int at; logic [1:0] pull; logic flt; logic lk; string tag;
  } exp_t;
  exp_t sbq[$];

  assign rq_in = ~(rq_pull | m_low);
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rqgt_handover #(.NCH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .tstate(tstate), .odd_low(odd_low),
    .first_ack(first_ack), .inta_cyc(inta_cyc), .locked(locked),
    .rq_in(rq_in), .rq_pull(rq_pull), .bus_float(bus_float),
    .stall(stall), .lock_n(lock_n)
  );

  task automatic push(logic [1:0] p, logic f, logic lk, string tag);
    exp_t e;
    e.at = cyc; e.pull = p; e.flt = f; e.lk = lk; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic step(logic [2:0] ts, logic [1:0] ml, logic [3:0] fl,
                      logic [1:0] p, logic f, logic lk, string tag);
    @(posedge clk); #1;
    tstate = ts; m_low = ml;
    {odd_low, first_ack, inta_cyc, locked} = fl;
    push(p, f, lk, tag);
  endtask

  always @(negedge clk) begin
    while (rst_n && sbq.size() > 0 && sbq[0].at <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      total++;
      if (e.at < cyc || rq_pull !== e.pull || bus_float !== e.flt ||
          stall !== e.flt || lock_n !== e.lk) begin
        bad++;
        $display("FAIL %s: got pull=%b float=%b stall=%b lock_n=%b exp pull=%b float=%b stall=%b lock_n=%b",
                 e.tag, rq_pull, bus_float, stall, lock_n, e.pull, e.flt, e.flt, e.lk);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1..: run did not finish, got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push(2'b00, 1'b0, 1'b1, "R1 reset state");

    // R2 R3 idle handover, R9 lock floats high in hold
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R1 quiet");
    step(TI, 2'b01, F_NONE, 2'b00, 0, 1, "R2 request clock");
    step(TI, 2'b00, F_NONE, 2'b01, 0, 1, "R2 grant pulse");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held");
    step(TI, 2'b00, F_LOCK, 2'b00, 1, 1, "R9 lock high in hold");
    step(TI, 2'b01, F_NONE, 2'b00, 1, 1, "R3 release clock");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R3 reclaimed");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R3 no regrant");

    // R4 late request at T3
    step(T1, 2'b00, F_NONE, 2'b00, 0, 1, "R4 T1");
    step(T2, 2'b00, F_NONE, 2'b00, 0, 1, "R4 T2");
    step(T3, 2'b10, F_NONE, 2'b00, 0, 1, "R4 late request");
    step(T4, 2'b00, F_NONE, 2'b00, 0, 1, "R4 late not granted");
    step(T1, 2'b00, F_NONE, 2'b00, 0, 1, "R4 T1 b");
    step(T2, 2'b00, F_NONE, 2'b00, 0, 1, "R4 T2 b");
    step(T3, 2'b00, F_NONE, 2'b00, 0, 1, "R4 T3 b");
    step(T4, 2'b00, F_NONE, 2'b10, 0, 1, "R4 granted next T4");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held ch1");
    step(TI, 2'b10, F_NONE, 2'b00, 1, 1, "R3 release ch1");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R3 reclaimed ch1");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R8 gap");

    // R4 request at T2 served same T4
    step(T1, 2'b00, F_NONE, 2'b00, 0, 1, "R4 T1 c");
    step(T2, 2'b01, F_NONE, 2'b00, 0, 1, "R4 request at T2");
    step(T3, 2'b00, F_NONE, 2'b00, 0, 1, "R4 T3 c");
    step(T4, 2'b00, F_NONE, 2'b01, 0, 1, "R4 granted same T4");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held c");
    step(TI, 2'b01, F_NONE, 2'b00, 1, 1, "R3 release c");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R3 reclaimed c");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R8 gap c");

    // R5 blocking flags at T4
    step(T1, 2'b01, F_NONE, 2'b00, 0, 1, "R5 request at T1");
    step(T2, 2'b00, F_NONE, 2'b00, 0, 1, "R5 T2");
    step(T3, 2'b00, F_NONE, 2'b00, 0, 1, "R5 T3");
    step(T4, 2'b00, F_ODD,  2'b00, 0, 1, "R5 odd low byte blocks");
    step(T1, 2'b00, F_NONE, 2'b00, 0, 1, "R5 T1 b");
    step(T2, 2'b00, F_NONE, 2'b00, 0, 1, "R5 T2 b");
    step(T3, 2'b00, F_NONE, 2'b00, 0, 1, "R5 T3 b");
    step(T4, 2'b00, F_FIRST, 2'b00, 0, 1, "R5 first ack blocks");
    step(T1, 2'b00, F_NONE, 2'b00, 0, 1, "R5 T1 c");
    step(T2, 2'b00, F_NONE, 2'b00, 0, 1, "R5 T2 c");
    step(T3, 2'b00, F_NONE, 2'b00, 0, 1, "R5 T3 c");
    step(T4, 2'b00, F_NONE, 2'b01, 0, 1, "R5 granted when clear");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held d");
    step(TI, 2'b01, F_NONE, 2'b00, 1, 1, "R3 release d");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R3 reclaimed d");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R8 gap d");

    // R6 lock blocks, R2 long low is one request
    step(TI, 2'b01, F_LOCK, 2'b00, 0, 0, "R6 locked no grant");
    step(TI, 2'b01, F_LOCK, 2'b00, 0, 0, "R6 locked b");
    step(TI, 2'b01, F_LOCK, 2'b00, 0, 0, "R6 locked c");
    step(TI, 2'b00, F_LOCK, 2'b00, 0, 0, "R6 locked d");
    step(TI, 2'b00, F_NONE, 2'b01, 0, 1, "R6 grant once lock clears");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held e");
    step(TI, 2'b01, F_NONE, 2'b00, 1, 1, "R3 release e");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R3 reclaimed e");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R2 long low counted once");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R2 long low counted once b");

    // R7 priority, R8 pending through hold
    step(TI, 2'b10, F_LOCK, 2'b00, 0, 0, "R7 ch1 pending");
    step(TI, 2'b00, F_LOCK, 2'b00, 0, 0, "R7 wait");
    step(TI, 2'b01, F_LOCK, 2'b00, 0, 0, "R7 ch0 pending");
    step(TI, 2'b00, F_NONE, 2'b01, 0, 1, "R7 channel 0 wins");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held f");
    step(TI, 2'b01, F_NONE, 2'b00, 1, 1, "R3 release f");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R8 idle clock no grant");
    step(TI, 2'b00, F_NONE, 2'b10, 0, 1, "R8 waiting channel served");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held g");
    step(TI, 2'b10, F_NONE, 2'b00, 1, 1, "R3 release g");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R3 reclaimed g");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R8 gap g");

    // R8 release and new request in the same clock
    step(TI, 2'b01, F_NONE, 2'b00, 0, 1, "R2 request h");
    step(TI, 2'b00, F_NONE, 2'b01, 0, 1, "R2 grant h");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held h");
    step(TI, 2'b11, F_NONE, 2'b00, 1, 1, "R8 release with ch1 request");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R8 idle clock h");
    step(TI, 2'b00, F_NONE, 2'b10, 0, 1, "R8 colliding request served");
    step(TI, 2'b00, F_NONE, 2'b00, 1, 1, "R3 held i");
    step(TI, 2'b10, F_NONE, 2'b00, 1, 1, "R3 release i");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R3 reclaimed i");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R8 gap i");

    // R9 acknowledge pair lock
    step(T1, 2'b00, F_INTA | F_FIRST, 2'b00, 0, 1, "R9 first ack T1");
    step(T2, 2'b00, F_INTA | F_FIRST, 2'b00, 0, 1, "R9 not yet at T2");
    step(T3, 2'b00, F_INTA | F_FIRST, 2'b00, 0, 0, "R9 lock after first T2");
    step(T4, 2'b00, F_INTA | F_FIRST, 2'b00, 0, 0, "R9 lock T4");
    step(T1, 2'b00, F_INTA, 2'b00, 0, 0, "R9 second ack T1");
    step(T2, 2'b00, F_INTA, 2'b00, 0, 0, "R9 still low at second T2");
    step(T3, 2'b00, F_INTA, 2'b00, 0, 1, "R9 lock removed");
    step(T4, 2'b00, F_INTA, 2'b00, 0, 1, "R9 stays high");
    step(TI, 2'b00, F_NONE, 2'b00, 0, 1, "R1 final quiet");

    @(posedge clk); @(posedge clk); #1;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule